// File: doc/BRIEF.md
# Key-Protected Watchdog Timer with Early Warning

This block is an independent watchdog timer. A power-of-two prescaler produces ticks that decrement a 12-bit down-counter. When a tick arrives with the counter at zero, the block raises a one-cycle reset request and reloads the counter. Software keeps the system alive by writing a refresh key to the key register before the counter runs out. Once the watchdog has been started, software has no way to stop it. Only the block's own synchronous reset returns it to the stopped state.

Configuration lives in a small register set on a simple write bus with combinational read-back. Software must write an unlock key before it can change the division code, the reload value, the window value, or the early-warning settings. Any key value the block does not recognise removes that access again. A new division code or reload value is applied to the counter only after a fixed settling delay. During that delay, a status flag reports the update as pending. The settling delay stands in for the crossing into a slow clock domain. An optional early-warning interrupt is raised when the counter counts down to a programmed compare value. It stays raised until software acknowledges it or the counter is reloaded.

Top module: `keyed_watchdog`

## Requirements
- R1: After reset, read-back gives division code 0, reload 0xFFF, window 0xFFF, early control 0 and status 0. Both outputs are low, and the counter stays stopped with no output activity.
- R2: Register offsets are as follows:
  - 0x00: key.
  - 0x04: division code, bits 3:0.
  - 0x08: reload, bits 11:0.
  - 0x0C: status, read only.
  - 0x10: window, bits 11:0, stored only.
  - 0x14: early control. Bits 11:0 hold the compare value, bit 14 is the write-1 acknowledge, and bit 15 is the enable. Bit 14 reads as 0.

  Writes to the division code, reload, window, and the compare and enable fields are ignored unless key 0x5555 has been written.
- R3: Writing the key register with any value other than 0x5555, 0xAAAA or 0xCCCC removes write access. Writing 0xAAAA or 0xCCCC leaves write access unchanged.
- R4: An accepted division-code write sets status bit 0, and an accepted reload write sets status bit 1. Each flag stays set for PEND_CYCLES clock cycles after the write edge and then clears. The new value reaches the counter at the moment the flag clears.
- R5: Key 0xCCCC starts the watchdog. It loads the counter with the reload value and restarts the prescaler phase. The first one-cycle pulse on rst_req appears (reload+1)·ratio cycles after the start write edge. The counter then reloads, and the pulses repeat with that same period.
- R6: The prescaler ratio is 4·2^code. Codes above 8 behave as code 8, which gives a ratio of 1024.
- R7: Key 0xAAAA reloads the counter and restarts the prescaler phase, so the next deadline is measured from the latest refresh. No other key value refreshes the counter.
- R8: Once the watchdog is started, no key write stops it.
- R9: When the early-warning enable is set, early_irq rises (reload−compare)·ratio cycles after a start or refresh. This is the moment a decrement brings the counter to the compare value. early_irq then stays high.
- R10: Writing 1 to bit 14 of the early control register clears early_irq at that write edge. This acknowledge works without the unlock key.
- R11: Any reload of the counter clears early_irq. This covers expiry, refresh and start.
- R12: When the early-warning enable is 0, early_irq never rises.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for both the bus and the counter |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe, sampled at the rising edge |
| bus_addr | input | 5 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for bus_addr |
| rst_req | output | 1 | One-cycle reset request on expiry |
| early_irq | output | 1 | Early-warning interrupt level |

## Verification
The bound checker watches the following properties on every cycle:
- a reset request always lasts exactly one cycle;
- a stopped watchdog is silent, and a started one never stops;
- a locked reload write leaves the stored value unchanged;
- an acknowledge write or an expiry always leaves the interrupt low;
- the interrupt can only rise while the enable is set.

Only the bench scenarios can show the exact cycle counts. These cover expiry at each division ratio, including the clamped code, and the deadline restarting on a refresh. They also cover the interrupt's rise point, its clearing by acknowledge, by expiry and by refresh, and the length of the pending-update window.

// File: rtl/keyed_watchdog_pkg.sv
package keyed_watchdog_pkg;

    localparam int CNT_W      = 12;
    localparam int CODE_W     = 4;
    localparam int BASE_SHIFT = 2;
    localparam int MAX_CODE   = 8;
    localparam int PDIV_W     = BASE_SHIFT + MAX_CODE;
    localparam int DATA_W     = 32;
    localparam int ADDR_W     = 5;

    localparam logic [15:0] KEY_REFRESH = 16'hAAAA;
    localparam logic [15:0] KEY_UNLOCK  = 16'h5555;
    localparam logic [15:0] KEY_START   = 16'hCCCC;

    localparam int EW_ACK_BIT = 14;
    localparam int EW_EN_BIT  = 15;

    typedef enum logic [2:0] {
        SEL_KEY, SEL_PRE, SEL_RLD, SEL_STAT, SEL_WIN, SEL_EWC, SEL_NONE
    } reg_sel_e;

    typedef struct packed {
        logic start;
        logic refresh;
        logic ack;
    } key_cmd_t;

    typedef struct packed {
        logic [CODE_W-1:0] code;
        logic [CNT_W-1:0]  reload;
        logic [CNT_W-1:0]  cmp;
        logic              ew_en;
    } wd_cfg_t;

    function automatic reg_sel_e decode_addr(input logic [ADDR_W-1:0] a);
        case (a)
            5'h00:   return SEL_KEY;
            5'h04:   return SEL_PRE;
            5'h08:   return SEL_RLD;
            5'h0C:   return SEL_STAT;
            5'h10:   return SEL_WIN;
            5'h14:   return SEL_EWC;
            default: return SEL_NONE;
        endcase
    endfunction

    // Terminal value of the prescaler phase counter: 4*2^code - 1, clamped.
    function automatic logic [PDIV_W-1:0] ratio_m1(input logic [CODE_W-1:0] code);
        logic [CODE_W-1:0] c;
        logic [PDIV_W:0]   r;
        c = (code > CODE_W'(MAX_CODE)) ? CODE_W'(MAX_CODE) : code;
        r = (PDIV_W+1)'(1) << (BASE_SHIFT + int'(c));
        return PDIV_W'(r - 1'b1);
    endfunction

endpackage

// File: rtl/kw_regs.sv
module kw_regs
    import keyed_watchdog_pkg::*;
#(
    parameter int PEND_CYCLES = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output wd_cfg_t           cfg,
    output key_cmd_t          cmd,
    output logic              unlocked,
    output logic [CNT_W-1:0]  rld_shadow
);
    localparam int PB_W = $clog2(PEND_CYCLES + 1);
    localparam int NUPD = 2;

    reg_sel_e          sel;
    logic [15:0]       key;
    logic              key_wr;
    logic [CODE_W-1:0] pre_sh, pre_act;
    logic [CNT_W-1:0]  rld_sh, rld_act;
    logic [CNT_W-1:0]  win_q;
    logic [CNT_W-1:0]  cmp_q;
    logic              en_q;
    logic [NUPD-1:0]   upd_req;
    logic [NUPD-1:0]   pend_flag;
    logic [NUPD-1:0]   commit;

    assign sel    = decode_addr(bus_addr);
    assign key    = bus_wdata[15:0];
    assign key_wr = bus_wr && (sel == SEL_KEY);

    assign cmd.start   = key_wr && (key == KEY_START);
    assign cmd.refresh = key_wr && (key == KEY_REFRESH);
    assign cmd.ack     = bus_wr && (sel == SEL_EWC) && bus_wdata[EW_ACK_BIT];

    assign upd_req[0] = bus_wr && (sel == SEL_PRE) && unlocked;
    assign upd_req[1] = bus_wr && (sel == SEL_RLD) && unlocked;

    // One settling tracker per slow-domain value (code, reload).
    for (genvar i = 0; i < NUPD; i++) begin : g_pend
        logic [PB_W-1:0] left_q;
        always_ff @(posedge clk) begin
            if (rst)
                left_q <= '0;
            else if (upd_req[i])
                left_q <= PB_W'(PEND_CYCLES);
            else if (left_q != '0)
                left_q <= left_q - 1'b1;
        end
        assign pend_flag[i] = (left_q != '0);
        assign commit[i]    = (left_q == PB_W'(1)) && !upd_req[i];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            unlocked <= 1'b0;
            pre_sh   <= '0;
            rld_sh   <= '1;
            win_q    <= '1;
            cmp_q    <= '0;
            en_q     <= 1'b0;
        end else if (bus_wr) begin
            case (sel)
                SEL_KEY: begin
                    if (key == KEY_UNLOCK)
                        unlocked <= 1'b1;
                    else if (key != KEY_REFRESH && key != KEY_START)
                        unlocked <= 1'b0;
                end
                SEL_PRE: if (unlocked) pre_sh <= bus_wdata[CODE_W-1:0];
                SEL_RLD: if (unlocked) rld_sh <= bus_wdata[CNT_W-1:0];
                SEL_WIN: if (unlocked) win_q  <= bus_wdata[CNT_W-1:0];
                SEL_EWC: if (unlocked) begin
                    cmp_q <= bus_wdata[CNT_W-1:0];
                    en_q  <= bus_wdata[EW_EN_BIT];
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pre_act <= '0;
            rld_act <= '1;
        end else begin
            if (commit[0]) pre_act <= pre_sh;
            if (commit[1]) rld_act <= rld_sh;
        end
    end

    assign cfg.code   = pre_act;
    assign cfg.reload = rld_act;
    assign cfg.cmp    = cmp_q;
    assign cfg.ew_en  = en_q;
    assign rld_shadow = rld_sh;

    always_comb begin
        bus_rdata = '0;
        case (sel)
            SEL_PRE:  bus_rdata = DATA_W'(pre_sh);
            SEL_RLD:  bus_rdata = DATA_W'(rld_sh);
            SEL_STAT: bus_rdata = DATA_W'(pend_flag);
            SEL_WIN:  bus_rdata = DATA_W'(win_q);
            SEL_EWC: begin
                bus_rdata[CNT_W-1:0]  = cmp_q;
                bus_rdata[EW_EN_BIT]  = en_q;
            end
            default:  bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/kw_prescaler.sv
module kw_prescaler
    import keyed_watchdog_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              run,
    input  logic              restart,
    input  logic [CODE_W-1:0] code,
    output logic              tick
);
    logic [PDIV_W-1:0] phase_q;
    logic [PDIV_W-1:0] last;
    logic              at_end;

    assign last   = ratio_m1(code);
    assign at_end = (phase_q >= last);
    assign tick   = run && !restart && at_end;

    always_ff @(posedge clk) begin
        if (rst || restart || !run)
            phase_q <= '0;
        else if (at_end)
            phase_q <= '0;
        else
            phase_q <= phase_q + 1'b1;
    end
endmodule

// File: rtl/kw_counter.sv
module kw_counter
    import keyed_watchdog_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  key_cmd_t cmd,
    input  logic     tick,
    input  wd_cfg_t  cfg,
    output logic     running,
    output logic     rst_req,
    output logic     early_irq
);
    logic [CNT_W-1:0] cnt_q;
    logic             load;
    logic             step;
    logic             expire;
    logic             hit_cmp;

    assign load    = cmd.start || cmd.refresh;
    assign step    = running && tick && !load;
    assign expire  = step && (cnt_q == '0);
    assign hit_cmp = step && (cnt_q != '0) && cfg.ew_en
                     && ((cnt_q - 1'b1) == cfg.cmp);

    always_ff @(posedge clk) begin
        if (rst) begin
            running   <= 1'b0;
            cnt_q     <= '1;
            rst_req   <= 1'b0;
            early_irq <= 1'b0;
        end else begin
            rst_req <= expire;
            if (cmd.start)
                running <= 1'b1;

            if (load || expire)
                cnt_q <= cfg.reload;
            else if (step)
                cnt_q <= cnt_q - 1'b1;

            if (cmd.ack || load || expire)
                early_irq <= 1'b0;
            else if (hit_cmp)
                early_irq <= 1'b1;
        end
    end
endmodule

// File: rtl/keyed_watchdog.sv
module keyed_watchdog
    import keyed_watchdog_pkg::*;
#(
    parameter int PEND_CYCLES = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              rst_req,
    output logic              early_irq
);
    wd_cfg_t          cfg;
    key_cmd_t         cmd;
    logic             unlocked;
    logic [CNT_W-1:0] rld_shadow;
    logic             running;
    logic             tick;

    kw_regs #(.PEND_CYCLES(PEND_CYCLES)) u_regs (
        .clk        (clk),
        .rst        (rst),
        .bus_wr     (bus_wr),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .cfg        (cfg),
        .cmd        (cmd),
        .unlocked   (unlocked),
        .rld_shadow (rld_shadow)
    );

    kw_prescaler u_pre (
        .clk     (clk),
        .rst     (rst),
        .run     (running),
        .restart (cmd.start || cmd.refresh),
        .code    (cfg.code),
        .tick    (tick)
    );

    kw_counter u_cnt (
        .clk       (clk),
        .rst       (rst),
        .cmd       (cmd),
        .tick      (tick),
        .cfg       (cfg),
        .running   (running),
        .rst_req   (rst_req),
        .early_irq (early_irq)
    );
endmodule

// File: rtl/keyed_watchdog_chk.sv
module keyed_watchdog_chk
    import keyed_watchdog_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic              running,
    input logic              unlocked,
    input logic [CNT_W-1:0]  rld_shadow,
    input logic              ew_en,
    input logic              rst_req,
    input logic              early_irq
);
    // R5: the reset request is a single-cycle pulse
    a_r5_single_pulse: assert property (@(posedge clk) disable iff (rst)
        rst_req |=> !rst_req);

    // R1: a stopped watchdog produces no output activity
    a_r1_quiet_stopped: assert property (@(posedge clk) disable iff (rst)
        !running |-> (!rst_req && !early_irq));

    // R8: once running, the watchdog stays running
    a_r8_no_stop: assert property (@(posedge clk) disable iff (rst)
        running |=> running);

    // R2: a locked reload write leaves the stored value unchanged
    a_r2_locked_reload: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == 5'h08 && !unlocked) |=> $stable(rld_shadow));

    // R10: acknowledge leaves the interrupt low afterwards
    a_r10_ack_clears: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == 5'h14 && bus_wdata[EW_ACK_BIT]) |=> !early_irq);

    // R11: an expiry reload leaves the interrupt low
    a_r11_expiry_clears: assert property (@(posedge clk) disable iff (rst)
        rst_req |-> !early_irq);

    // R12: the interrupt rises only while enabled
    a_r12_needs_enable: assert property (@(posedge clk) disable iff (rst)
        $rose(early_irq) |-> $past(ew_en));
endmodule

bind keyed_watchdog keyed_watchdog_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .bus_wr     (bus_wr),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .running    (running),
    .unlocked   (unlocked),
    .rld_shadow (rld_shadow),
    .ew_en      (cfg.ew_en),
    .rst_req    (rst_req),
    .early_irq  (early_irq)
);

// File: tb/keyed_watchdog_test.sv
module keyed_watchdog_test;
    localparam int PEND = 4;
    localparam int EV_RST  = 0;
    localparam int EV_RISE = 1;
    localparam int EV_FALL = 2;

    typedef struct {
        int    kind;
        int    at;
        string tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        rst_req;
    logic        early_irq;

    int   cyc = 0;
    int   checks = 0;
    int   fails = 0;
    bit   prev_irq = 1'b0;
    bit   finished = 1'b0;
    exp_t q[$];

    keyed_watchdog #(.PEND_CYCLES(PEND)) uut (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .rst_req(rst_req), .early_irq(early_irq)
    );

    always #4 clk = ~clk;
    always @(posedge clk) cyc = cyc + 1;

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    task automatic push(input int kind, input int at, input string tag);
        exp_t e;
        e.kind = kind; e.at = at; e.tag = tag;
        q.push_back(e);
    endtask

    task automatic observe(input int kind);
        exp_t e;
        checks++;
        if (q.size() == 0) begin
            fails++;
            $display("FAIL unexpected event actual=kind%0d@%0d expected=none", kind, cyc);
        end else begin
            e = q.pop_front();
            if (e.kind != kind || e.at != cyc) begin
                fails++;
                $display("FAIL %s actual=kind%0d@%0d expected=kind%0d@%0d",
                         e.tag, kind, cyc, e.kind, e.at);
            end
        end
    endtask

    // Monitor: compares output events against the scoreboard queue.
    always @(negedge clk) begin
        if (rst) begin
            prev_irq = 1'b0;
        end else begin
            if (rst_req === 1'b1) observe(EV_RST);
            if (early_irq === 1'b1 && !prev_irq) observe(EV_RISE);
            if (early_irq === 1'b0 && prev_irq) observe(EV_FALL);
            prev_irq = (early_irq === 1'b1);
        end
    end

    // All tasks are entered at a falling edge; a write lands on edge cyc+1.
    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(posedge clk);
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd_chk(input logic [4:0] a, input int exp, input string tag);
        bus_addr = a;
        #1;
        chk(tag, int'(bus_rdata), exp);
    endtask

    task automatic wait_until(input int c);
        while (cyc < c) @(negedge clk);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        q.delete();
    endtask

    task automatic drain(input string tag);
        chk({tag, " all expected events seen"}, q.size(), 0);
        q.delete();
    endtask

    task automatic setup(input int code, input int rl, input int ewc);
        wr(5'h00, 32'h5555);
        wr(5'h04, 32'(code));
        wr(5'h08, 32'(rl));
        wr(5'h14, 32'(ewc));
        wr(5'h00, 32'h0000);          // lock again
        repeat (PEND + 2) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++; fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        int e0, er;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        rd_chk(5'h04, 0, "R1 code");
        rd_chk(5'h08, 'hFFF, "R1 reload");
        rd_chk(5'h0C, 0, "R1 status");
        rd_chk(5'h10, 'hFFF, "R1 window");
        rd_chk(5'h14, 0, "R1 early ctrl");
        chk("R1 rst_req", int'(rst_req), 0);
        chk("R1 early_irq", int'(early_irq), 0);
        repeat (100) @(negedge clk);
        drain("R1 stopped");

        // R2 write protection
        wr(5'h08, 32'h5);      rd_chk(5'h08, 'hFFF, "R2 locked reload");
        wr(5'h04, 32'h3);      rd_chk(5'h04, 0, "R2 locked code");
        wr(5'h10, 32'h7);      rd_chk(5'h10, 'hFFF, "R2 locked window");
        wr(5'h14, 32'h8005);   rd_chk(5'h14, 0, "R2 locked early ctrl");
        wr(5'h00, 32'h5555);
        wr(5'h08, 32'h9);
        // R4 pending flag for PEND cycles
        rd_chk(5'h0C, 2, "R4 reload pending");
        repeat (PEND - 1) @(negedge clk);
        rd_chk(5'h0C, 2, "R4 reload still pending");
        @(negedge clk);
        rd_chk(5'h0C, 0, "R4 reload flag cleared");
        rd_chk(5'h08, 9, "R2 unlocked reload");
        wr(5'h04, 32'h2);
        rd_chk(5'h0C, 1, "R4 code pending");
        rd_chk(5'h04, 2, "R2 unlocked code");
        // R3 foreign key relocks, defined keys keep access
        wr(5'h00, 32'h1234);
        wr(5'h08, 32'h5);      rd_chk(5'h08, 9, "R3 relocked");
        wr(5'h00, 32'h5555);
        wr(5'h00, 32'hAAAA);
        wr(5'h08, 32'h7);      rd_chk(5'h08, 7, "R3 refresh key keeps access");
        repeat (PEND + 2) @(negedge clk);
        do_reset();

        // R5 expiry period, ratio 4 (code 0), reload 9
        setup(0, 9, 0);
        e0 = cyc + 1;
        push(EV_RST, e0 + 40, "R5 first expiry");
        push(EV_RST, e0 + 80, "R5 second expiry");
        wr(5'h00, 32'hCCCC);
        wait_until(e0 + 90);
        drain("R5");
        do_reset();

        // R6 code 2 -> ratio 16, reload 3
        setup(2, 3, 0);
        e0 = cyc + 1;
        push(EV_RST, e0 + 64, "R6 ratio 16");
        wr(5'h00, 32'hCCCC);
        wait_until(e0 + 70);
        drain("R6 code2");
        do_reset();

        // R6 code 15 clamps to ratio 1024, reload 1
        setup(15, 1, 0);
        e0 = cyc + 1;
        push(EV_RST, e0 + 2048, "R6 clamped ratio");
        wr(5'h00, 32'hCCCC);
        wait_until(e0 + 2052);
        drain("R6 clamp");
        do_reset();

        // R7 refresh restarts deadline; R8 other keys neither refresh nor stop
        setup(0, 9, 0);
        e0 = cyc + 1;
        wr(5'h00, 32'hCCCC);
        er = e0;
        for (int i = 0; i < 4; i++) begin
            wait_until(er + 10);
            wr(5'h00, 32'h1234);
            wr(5'h00, 32'h5555);
            wait_until(er + 29);
            er = cyc + 1;
            if (i == 3) begin
                push(EV_RST, er + 40, "R7 deadline from last refresh");
                push(EV_RST, er + 80, "R8 keeps running after junk key");
            end
            wr(5'h00, 32'hAAAA);
        end
        wait_until(er + 50);
        wr(5'h00, 32'h0000);
        wr(5'h00, 32'hCCC0);
        wait_until(er + 85);
        drain("R7/R8");
        do_reset();

        // R9 rise, R10 acknowledge without unlock
        setup(0, 9, 'h8005);
        e0 = cyc + 1;
        push(EV_RISE, e0 + 16, "R9 early rise");
        wr(5'h00, 32'hCCCC);
        wait_until(e0 + 19);
        push(EV_FALL, e0 + 20, "R10 ack clears");
        push(EV_RST, e0 + 40, "R5 expiry with irq");
        push(EV_RISE, e0 + 56, "R9 rise again");
        wr(5'h14, 32'h4000);
        rd_chk(5'h14, 'h8005, "R10 ack keeps locked fields");
        wait_until(e0 + 60);
        drain("R9/R10");
        do_reset();

        // R11 expiry and refresh clear the interrupt
        setup(0, 9, 'h8005);
        e0 = cyc + 1;
        push(EV_RISE, e0 + 16, "R9 rise");
        push(EV_RST, e0 + 40, "R5 expiry");
        push(EV_FALL, e0 + 40, "R11 expiry clears");
        push(EV_RISE, e0 + 56, "R9 rise after expiry");
        push(EV_RST, e0 + 80, "R5 expiry 2");
        push(EV_FALL, e0 + 80, "R11 expiry clears 2");
        push(EV_RISE, e0 + 96, "R9 rise 3");
        push(EV_FALL, e0 + 100, "R11 refresh clears");
        wr(5'h00, 32'hCCCC);
        wait_until(e0 + 99);
        wr(5'h00, 32'hAAAA);
        wait_until(e0 + 105);
        drain("R11");
        do_reset();

        // R12 disabled early warning never rises
        setup(0, 9, 'h0005);
        e0 = cyc + 1;
        push(EV_RST, e0 + 40, "R12 expiry only");
        push(EV_RST, e0 + 80, "R12 expiry only 2");
        wr(5'h00, 32'hCCCC);
        wait_until(e0 + 85);
        drain("R12");
        chk("R12 early_irq low", int'(early_irq), 0);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule